// File: doc/BRIEF.md
# Power-of-Two Oversampling Averager

This block sits between a 10-bit converter's result output and the result queue. Each conversion step produces one result. For each step the block takes a number of raw conversions, 2 raised to an exponent, adds them up and sends one truncated mean downstream. While the block still needs more raw samples for the current step, it holds a request line high toward the conversion sequencer. The exponent is a static 3-bit setting and applies to every step alike. A value of zero disables averaging, and each raw sample is then passed through unchanged.

A step begins with a one-cycle start pulse. The start pulse clears any partial sum and sample count, and it captures the exponent for the step. Output throughput is therefore the raw sample rate divided by the oversampling factor.

Top module: `ovs_avg`

## Requirements
- R1: After reset, `conv_req_o` and `res_valid_o` are low and `res_data_o` is zero.
- R2: From the cycle after a `step_start_i` pulse, `conv_req_o` stays high until the cycle after the last required raw sample is accepted. In that cycle it goes low.
- R3: With an exponent of 0, a single accepted raw sample ends the step. `res_data_o` then equals that sample, and `res_valid_o` is high the cycle after it was accepted.
- R4: With an exponent k from 1 to 6, exactly 2^k accepted samples give one result. The result is floor(sum / 2^k), and it is valid the cycle after the 2^k-th sample.
- R5: An exponent value of 7 behaves exactly like 6, so 64 samples are averaged.
- R6: The exponent is captured on the `step_start_i` cycle. Changing `avg_exp_i` during a step does not change the sample count or the divisor of that step.
- R7: A `step_start_i` pulse in the middle of a step discards the partial sum and count. The step that follows averages only its own samples.
- R8: A raw sample offered while `conv_req_o` is low is ignored. It produces no result and does not enter the next step's sum.
- R9: A raw sample offered in the same cycle as `step_start_i` is ignored.
- R10: `res_valid_o` is a one-cycle pulse, once per completed step. `res_data_o` holds its value until the next result.
- R11: Sample gaps (cycles with `raw_valid_i` low) while `conv_req_o` is high do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| avg_exp_i | input | 3 | Oversampling exponent; factor is 2^value, 7 treated as 6 |
| step_start_i | input | 1 | One-cycle pulse that begins a new step |
| raw_valid_i | input | 1 | Raw conversion present on `raw_data_i` |
| raw_data_i | input | 10 | Raw conversion value |
| conv_req_o | output | 1 | Another raw conversion is needed for the current step |
| res_valid_o | output | 1 | One-cycle strobe for an averaged result |
| res_data_o | output | 10 | Averaged result |

## Verification
The checker assumes that raw samples only matter while the request line is high. It also assumes the sequencer never starts a new step in the same cycle as it delivers the final sample it expects a result from. The directed stimulus pulses the step start for exactly one cycle. It offers data only at the points each scenario intends to test, and it deliberately places stray samples in idle cycles and on the start cycle to exercise R8 and R9. Under those input conditions, the checker tracks its own count of accepted samples and its own latched exponent. It then confirms that a result appears only after the full set of samples has arrived, and that the request line never stays high past that point.

// File: rtl/ovs_avg_pkg.sv
package ovs_avg_pkg;
    parameter int unsigned RAW_W   = 10;
    parameter int unsigned EXP_W   = 3;
    parameter int unsigned MAX_EXP = 6;

    localparam int unsigned ACC_W = RAW_W + MAX_EXP;
    localparam int unsigned CNT_W = MAX_EXP + 1;

    typedef logic [RAW_W-1:0] raw_t;
    typedef logic [EXP_W-1:0] exp_t;
    typedef logic [ACC_W-1:0] acc_t;
    typedef logic [CNT_W-1:0] cnt_t;

    function automatic exp_t limit_exp(exp_t e);
        if (e > exp_t'(MAX_EXP)) return exp_t'(MAX_EXP);
        return e;
    endfunction
endpackage

// File: rtl/ovs_cfg_latch.sv
module ovs_cfg_latch
    import ovs_avg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_start,
    input  exp_t exp_in,
    output exp_t exp_q
);
    typedef struct packed {
        exp_t exp;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_start) begin
            st_d.exp = limit_exp(exp_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exp_q = st_q.exp;
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
    import ovs_avg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic accept,
    input  raw_t raw,
    input  exp_t exp,
    output logic last,
    output acc_t total
);
    typedef struct packed {
        acc_t acc;
        cnt_t cnt;
    } acc_st_t;

    acc_st_t st_d, st_q;
    cnt_t    target;
    cnt_t    cnt_next;

    assign target   = cnt_t'(1) << exp;
    assign cnt_next = st_q.cnt + cnt_t'(1);
    assign last     = (cnt_next == target);
    assign total    = st_q.acc + acc_t'(raw);

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end else if (accept) begin
            if (last) begin
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = total;
                st_d.cnt = cnt_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ovs_seq_ctrl.sv
module ovs_seq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic step_start,
    input  logic raw_valid,
    input  logic last,
    output logic accept,
    output logic finish,
    output logic busy
);
    typedef struct packed {
        logic busy;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    assign accept = st_q.busy & raw_valid & ~step_start;
    assign finish = accept & last;

    always_comb begin
        st_d = st_q;
        if (step_start) begin
            st_d.busy = 1'b1;
        end else if (finish) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/ovs_result.sv
module ovs_result
    import ovs_avg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic finish,
    input  acc_t total,
    input  exp_t exp,
    output logic res_valid,
    output raw_t res_data
);
    typedef struct packed {
        logic valid;
        raw_t data;
    } res_st_t;

    res_st_t st_d, st_q;
    acc_t    shifted;

    assign shifted = total >> exp;

    always_comb begin
        st_d       = st_q;
        st_d.valid = finish;
        if (finish) begin
            st_d.data = shifted[RAW_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign res_data  = st_q.data;
endmodule

// File: rtl/ovs_avg.sv
module ovs_avg
    import ovs_avg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXP_W-1:0]      avg_exp_i,
    input  logic                  step_start_i,
    input  logic                  raw_valid_i,
    input  logic [RAW_W-1:0]      raw_data_i,
    output logic                  conv_req_o,
    output logic                  res_valid_o,
    output logic [RAW_W-1:0]      res_data_o
);
    exp_t exp_q;
    logic accept;
    logic finish;
    logic last;
    acc_t total;

    ovs_cfg_latch u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_start (step_start_i),
        .exp_in     (avg_exp_i),
        .exp_q      (exp_q)
    );

    ovs_seq_ctrl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_start (step_start_i),
        .raw_valid  (raw_valid_i),
        .last       (last),
        .accept     (accept),
        .finish     (finish),
        .busy       (conv_req_o)
    );

    ovs_accum u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (step_start_i),
        .accept (accept),
        .raw    (raw_data_i),
        .exp    (exp_q),
        .last   (last),
        .total  (total)
    );

    ovs_result u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .finish    (finish),
        .total     (total),
        .exp       (exp_q),
        .res_valid (res_valid_o),
        .res_data  (res_data_o)
    );
endmodule

// File: rtl/ovs_avg_chk.sv
module ovs_avg_chk
    import ovs_avg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [EXP_W-1:0] avg_exp_i,
    input logic             step_start_i,
    input logic             raw_valid_i,
    input logic [RAW_W-1:0] raw_data_i,
    input logic             conv_req_o,
    input logic             res_valid_o,
    input logic [RAW_W-1:0] res_data_o
);
    logic [EXP_W-1:0] mon_exp;
    logic [CNT_W:0]   mon_cnt;
    logic [CNT_W:0]   mon_need;

    assign mon_need = (CNT_W+1)'(1) << mon_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_exp <= '0;
            mon_cnt <= '0;
        end else if (step_start_i) begin
            mon_exp <= (avg_exp_i >= EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : avg_exp_i;
            mon_cnt <= '0;
        end else if (conv_req_o && raw_valid_i) begin
            mon_cnt <= mon_cnt + 1'b1;
        end
    end

    // R2
    req_within_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |-> (mon_cnt < mon_need));

    // R2
    req_drops_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !conv_req_o);

    // R4
    full_set_before_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (mon_cnt == mon_need));

    // R3
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && mon_exp == '0) |-> (res_data_o == $past(raw_data_i)));

    // R8
    idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_req_o |=> !res_valid_o);

    // R9
    start_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_start_i |=> (conv_req_o && !res_valid_o));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |=> (res_valid_o || $stable(res_data_o)));
endmodule

bind ovs_avg ovs_avg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .avg_exp_i    (avg_exp_i),
    .step_start_i (step_start_i),
    .raw_valid_i  (raw_valid_i),
    .raw_data_i   (raw_data_i),
    .conv_req_o   (conv_req_o),
    .res_valid_o  (res_valid_o),
    .res_data_o   (res_data_o)
);

// File: tb/ovs_avg_bench.sv
module ovs_avg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] avg_exp_i = '0;
    logic       step_start_i = 1'b0;
    logic       raw_valid_i = 1'b0;
    logic [9:0] raw_data_i = '0;
    logic       conv_req_o;
    logic       res_valid_o;
    logic [9:0] res_data_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ovs_avg u_ovs_avg (
        .clk          (clk),
        .rst_n        (rst_n),
        .avg_exp_i    (avg_exp_i),
        .step_start_i (step_start_i),
        .raw_valid_i  (raw_valid_i),
        .raw_data_i   (raw_data_i),
        .conv_req_o   (conv_req_o),
        .res_valid_o  (res_valid_o),
        .res_data_o   (res_data_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int sample_val(input int i, input int pat);
        case (pat)
            0:       return (i * 16 + 3) % 1024;
            1:       return 1023;
            2:       return (i * 613 + 97) % 1024;
            default: return i % 2;
        endcase
    endfunction

    task automatic pulse_start(input int e);
        @(negedge clk);
        avg_exp_i    = 3'(e);
        step_start_i = 1'b1;
        @(negedge clk);
        step_start_i = 1'b0;
    endtask

    // Feeds one full step and checks request, result timing and value.
    task automatic feed_step(input string req, input int eff, input int pat,
                             input bit gaps);
        int n = 1 << eff;
        int sum = 0;
        int expv;
        check(conv_req_o == 1'b1, "R2", "request after start", conv_req_o, 1);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                raw_valid_i = 1'b0;
                @(negedge clk);
                check(res_valid_o == 1'b0, "R11", "no result in gap", res_valid_o, 0);
                check(conv_req_o == 1'b1, "R11", "request in gap", conv_req_o, 1);
            end
            raw_valid_i = 1'b1;
            raw_data_i  = 10'(sample_val(i, pat));
            sum += sample_val(i, pat);
            @(negedge clk);
            if (i < n - 1) begin
                check(res_valid_o == 1'b0, req, "early result", res_valid_o, 0);
                check(conv_req_o == 1'b1, "R2", "request held", conv_req_o, 1);
            end
        end
        raw_valid_i = 1'b0;
        expv = sum >> eff;
        check(res_valid_o == 1'b1, req, "result strobe", res_valid_o, 1);
        check(int'(res_data_o) == expv, req, "result value", res_data_o, expv);
        check(conv_req_o == 1'b0, "R2", "request dropped", conv_req_o, 0);
        @(negedge clk);
        check(res_valid_o == 1'b0, "R10", "strobe one cycle", res_valid_o, 0);
        check(int'(res_data_o) == expv, "R10", "data held", res_data_o, expv);
    endtask

    task automatic t_reset();
        check(conv_req_o == 1'b0, "R1", "reset request", conv_req_o, 0);
        check(res_valid_o == 1'b0, "R1", "reset strobe", res_valid_o, 0);
        check(res_data_o == '0, "R1", "reset data", res_data_o, 0);
    endtask

    task automatic t_passthrough();
        pulse_start(0);
        feed_step("R3", 0, 2, 1'b0);
        pulse_start(0);
        feed_step("R3", 0, 1, 1'b0);
    endtask

    task automatic t_all_factors();
        for (int e = 1; e <= 6; e++) begin
            pulse_start(e);
            feed_step("R4", e, e % 4, (e == 3));
        end
    endtask

    task automatic t_clamp();
        pulse_start(7);
        feed_step("R5", 6, 2, 1'b0);
    endtask

    task automatic t_midstep_change();
        @(negedge clk);
        avg_exp_i    = 3'd2;
        step_start_i = 1'b1;
        @(negedge clk);
        step_start_i = 1'b0;
        avg_exp_i    = 3'd5;
        feed_step("R6", 2, 0, 1'b0);
    endtask

    task automatic t_restart();
        pulse_start(3);
        for (int i = 0; i < 5; i++) begin
            raw_valid_i = 1'b1;
            raw_data_i  = 10'd1000;
            @(negedge clk);
        end
        raw_valid_i = 1'b0;
        check(res_valid_o == 1'b0, "R7", "partial no result", res_valid_o, 0);
        pulse_start(3);
        feed_step("R7", 3, 3, 1'b0);
    endtask

    task automatic t_idle_ignore();
        int last_data = int'(res_data_o);
        for (int i = 0; i < 4; i++) begin
            raw_valid_i = 1'b1;
            raw_data_i  = 10'd1023;
            @(negedge clk);
            check(res_valid_o == 1'b0, "R8", "idle sample result", res_valid_o, 0);
            check(conv_req_o == 1'b0, "R8", "idle request", conv_req_o, 0);
        end
        raw_valid_i = 1'b0;
        check(int'(res_data_o) == last_data, "R8", "idle data", res_data_o, last_data);
        pulse_start(1);
        feed_step("R8", 1, 0, 1'b0);
    endtask

    task automatic t_start_collision();
        @(negedge clk);
        avg_exp_i    = 3'd1;
        step_start_i = 1'b1;
        raw_valid_i  = 1'b1;
        raw_data_i   = 10'd1000;
        @(negedge clk);
        step_start_i = 1'b0;
        raw_valid_i  = 1'b0;
        check(res_valid_o == 1'b0, "R9", "start sample result", res_valid_o, 0);
        feed_step("R9", 1, 3, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_all_factors();
        t_clamp();
        t_midstep_change();
        t_restart();
        t_idle_ignore();
        t_start_collision();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule